// File: doc/BRIEF.md
# Two-Domain Hierarchical Bus Arbiter

This block shares one bus among five masters that sit in two groups. The main group holds a processor, a DMA engine and a memory refresh engine. The local group holds a display engine and a USB host. Each group has its own priority picker. A top stage then chooses between the two groups, and the two groups carry the same weight there. Each master raises a request and gets back one bit of a one-hot grant vector. The grant stays on until the master signals that its transaction is over. The one exception is a DMA grant in cycle-steal mode, which lasts for a single transfer.

How the DMA engine ranks against the processor depends on a mode input. In burst mode the DMA engine always beats the processor. In cycle-steal mode the two are equals. Refresh beats both of them in every mode. Masters of equal rank are ordered by round-robin, so the master that was granted last loses the next tie. The same rule applies to the two groups at the top stage.

Top module: `hier_bus_arb`

## Requirements
- R1: At most one bit of `gnt_o` is ever high, and a new grant only goes to a master whose request bit was high in the cycle that was arbitrated. Bit positions of `req_i`, `done_i` and `gnt_o`: 0 processor, 1 DMA, 2 refresh, 3 display, 4 USB host.
- R2: Arbitration happens only in a cycle where `gnt_o` is all zero, and the result shows on `gnt_o` after the next rising clock edge. After a release, `gnt_o` is zero for one cycle before the next grant.
- R3: In the main group, a refresh request wins over the processor and the DMA engine in either DMA mode.
- R4: While `dma_burst_i` is 1 (burst mode), a DMA request wins over a processor request every time, including back-to-back.
- R5: While `dma_burst_i` is 0 (cycle-steal mode), the processor and the DMA engine alternate on ties. The processor takes the first tie after reset.
- R6: A DMA grant given while `dma_burst_i` is 0 lasts exactly one cycle and then drops without any `done_i`.
- R7: Display and USB host alternate on ties. Display takes the first tie after reset.
- R8: When both groups request, the groups alternate. The main group takes the first such tie after reset.
- R9: A grant stays unchanged until the owner's `done_i` bit is high, whatever the length of the transaction (one to four beats for the USB host) and even if the owner drops its request.
- R10: A high `done_i` bit of the grant owner clears `gnt_o` on the next edge. `done_i` bits of masters that do not hold the grant have no effect.
- R11: With no request pending, `gnt_o` stays zero. A synchronous active-high `rst` clears the grant and all round-robin state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Request per master (bit map in R1) |
| done_i | input | 5 | End-of-transaction strobe per master |
| dma_burst_i | input | 1 | DMA mode: 1 burst, 0 cycle-steal |
| gnt_o | output | 5 | One-hot grant, registered |

## Verification
A corrupted round-robin pointer shows up at the very next tie in its pair or at the top stage. The wrong master is granted one edge after arbitration. For that reason the bench runs each tie pattern at least twice in a row from a known reset state. A stale cycle-steal flag or a lost grant bit either ends a grant before `done_i` or keeps it after `done_i`. Both faults are visible on `gnt_o` one cycle after the cause, so the bench samples the grant on every cycle of a held transaction.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
    localparam int unsigned N_MST   = 5;
    localparam int unsigned N_MAIN  = 3;
    localparam int unsigned N_LOCAL = N_MST - N_MAIN;

    localparam int unsigned M_PROC = 0;
    localparam int unsigned M_DMA  = 1;
    localparam int unsigned M_RFSH = 2;
    localparam int unsigned M_DISP = 3;
    localparam int unsigned M_USB  = 4;

    typedef logic [N_MST-1:0]   mst_vec_t;
    typedef logic [N_MAIN-1:0]  main_vec_t;
    typedef logic [N_LOCAL-1:0] loc_vec_t;

    typedef struct packed {
        mst_vec_t gnt;       // current owner, one-hot or zero
        logic     steal;     // owner is DMA in cycle-steal mode
        logic     pref_dma;  // processor/DMA tie goes to DMA
        logic     pref_usb;  // display/USB tie goes to USB
        logic     pref_loc;  // group tie goes to local group
    } arb_state_t;
endpackage

// File: rtl/rr2_pick.sv
module rr2_pick (
    input  logic req_a,
    input  logic req_b,
    input  logic pref_b,
    output logic win_a,
    output logic win_b
);
    always_comb begin
        win_a = req_a & (~req_b | ~pref_b);
        win_b = req_b & (~req_a |  pref_b);
    end
endmodule

// File: rtl/main_dom_pick.sv
module main_dom_pick
    import busarb_pkg::*;
(
    input  main_vec_t req,
    input  logic      burst,
    input  logic      pref_dma,
    output main_vec_t win
);
    logic pd_proc, pd_dma;
    logic gate_pd;

    // refresh masks the lower pair entirely
    assign gate_pd = ~req[M_RFSH];

    // burst mode forces the tie toward DMA
    rr2_pick u_pd (
        .req_a  (req[M_PROC] & gate_pd),
        .req_b  (req[M_DMA]  & gate_pd),
        .pref_b (burst | pref_dma),
        .win_a  (pd_proc),
        .win_b  (pd_dma)
    );

    always_comb begin
        win         = '0;
        win[M_RFSH] = req[M_RFSH];
        win[M_PROC] = pd_proc;
        win[M_DMA]  = pd_dma;
    end
endmodule

// File: rtl/hier_bus_arb.sv
module hier_bus_arb
    import busarb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [N_MST-1:0] req_i,
    input  logic [N_MST-1:0] done_i,
    input  logic           dma_burst_i,
    output logic [N_MST-1:0] gnt_o
);
    arb_state_t st_d, st_q;

    main_vec_t main_win;
    loc_vec_t  loc_win;
    logic      any_main, any_loc;
    logic      top_main, top_loc;
    mst_vec_t  pick;

    main_dom_pick u_main (
        .req      (req_i[N_MAIN-1:0]),
        .burst    (dma_burst_i),
        .pref_dma (st_q.pref_dma),
        .win      (main_win)
    );

    rr2_pick u_loc (
        .req_a  (req_i[M_DISP]),
        .req_b  (req_i[M_USB]),
        .pref_b (st_q.pref_usb),
        .win_a  (loc_win[0]),
        .win_b  (loc_win[1])
    );

    assign any_main = |req_i[N_MAIN-1:0];
    assign any_loc  = |req_i[N_MST-1:N_MAIN];

    rr2_pick u_top (
        .req_a  (any_main),
        .req_b  (any_loc),
        .pref_b (st_q.pref_loc),
        .win_a  (top_main),
        .win_b  (top_loc)
    );

    always_comb begin
        pick = '0;
        if (top_main) begin
            pick[N_MAIN-1:0] = main_win;
        end else if (top_loc) begin
            pick[N_MST-1:N_MAIN] = loc_win;
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.gnt != '0) begin
            // bus owned: release on single-transfer steal or owner done
            if (st_q.steal || ((st_q.gnt & done_i) != '0)) begin
                st_d.gnt   = '0;
                st_d.steal = 1'b0;
            end
        end else begin
            st_d.gnt   = pick;
            st_d.steal = pick[M_DMA] & ~dma_burst_i;
            if (pick[M_PROC] | pick[M_DMA]) begin
                st_d.pref_dma = pick[M_PROC];
            end
            if (pick[M_DISP] | pick[M_USB]) begin
                st_d.pref_usb = pick[M_DISP];
            end
            if (pick != '0) begin
                st_d.pref_loc = top_main;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o = st_q.gnt;
endmodule

// File: rtl/busarb_chk.sv
module busarb_chk
    import busarb_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [N_MST-1:0] req_i,
    input logic [N_MST-1:0] done_i,
    input logic           dma_burst_i,
    input logic [N_MST-1:0] gnt_o
);
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o)); // R1

    AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != '0 && $past(gnt_o) == '0) |-> (($past(req_i) & gnt_o) != '0)); // R1

    AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == '0 && req_i[M_RFSH] && !req_i[M_DISP] && !req_i[M_USB]) |=> gnt_o[M_RFSH]); // R3

    AST_BURST_DMA: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == '0 && req_i[M_DMA] && !req_i[M_RFSH] && dma_burst_i)
        |=> (gnt_o[M_DMA] || gnt_o[M_DISP] || gnt_o[M_USB])); // R4

    AST_STEAL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ($rose(gnt_o[M_DMA]) && !$past(dma_burst_i)) |=> !gnt_o[M_DMA]); // R6

    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != '0 && !gnt_o[M_DMA] && (gnt_o & done_i) == '0) |=> $stable(gnt_o)); // R9

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ((gnt_o & done_i) != '0) |=> gnt_o == '0); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == '0 && req_i == '0) |=> gnt_o == '0); // R11
endmodule

bind hier_bus_arb busarb_chk u_chk (.*);

// File: tb/hier_bus_arb_tb.sv
module hier_bus_arb_tb;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] req_i = '0;
    logic [4:0] done_i = '0;
    logic       dma_burst_i = 1'b0;
    logic [4:0] gnt_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    localparam logic [4:0] G_PROC = 5'b00001;
    localparam logic [4:0] G_DMA  = 5'b00010;
    localparam logic [4:0] G_RFSH = 5'b00100;
    localparam logic [4:0] G_DISP = 5'b01000;
    localparam logic [4:0] G_USB  = 5'b10000;
    localparam logic [4:0] G_NONE = 5'b00000;

    hier_bus_arb u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .done_i(done_i),
        .dma_burst_i(dma_burst_i), .gnt_o(gnt_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_i = '0; done_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive a request pattern, expect a grant, then release it
    task automatic grant_once(input logic [4:0] rq, input logic burst,
                              input logic [4:0] exp, input bit by_done, input string tag);
        req_i = rq; dma_burst_i = burst;
        @(negedge clk);
        chk(gnt_o, exp, tag);
        if (by_done) done_i = exp;
        @(negedge clk);
        chk(gnt_o, G_NONE, by_done ? "R10 release on done" : "R6 steal single cycle");
        done_i = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(gnt_o, G_NONE, "R11 grant after reset");
        rst = 1'b0;
    endtask

    task automatic t_refresh();
        do_reset();
        grant_once(5'b00111, 1'b0, G_RFSH, 1'b1, "R3 refresh over all (steal)");
        grant_once(5'b00111, 1'b1, G_RFSH, 1'b1, "R3 refresh over all (burst)");
    endtask

    task automatic t_burst();
        do_reset();
        grant_once(5'b00011, 1'b1, G_DMA, 1'b1, "R4 burst dma first");
        grant_once(5'b00011, 1'b1, G_DMA, 1'b1, "R4 burst dma again");
    endtask

    task automatic t_steal();
        do_reset();
        grant_once(5'b00011, 1'b0, G_PROC, 1'b1, "R5 steal tie proc first");
        grant_once(5'b00011, 1'b0, G_DMA,  1'b0, "R5 steal tie dma next");
        grant_once(5'b00011, 1'b0, G_PROC, 1'b1, "R5 steal tie proc again");
    endtask

    task automatic t_local();
        do_reset();
        grant_once(5'b11000, 1'b0, G_DISP, 1'b1, "R7 local tie display first");
        grant_once(5'b11000, 1'b0, G_USB,  1'b1, "R7 local tie usb next");
        grant_once(5'b11000, 1'b0, G_DISP, 1'b1, "R7 local tie display again");
    endtask

    task automatic t_top();
        do_reset();
        grant_once(5'b01001, 1'b0, G_PROC, 1'b1, "R8 group tie main first");
        grant_once(5'b01001, 1'b0, G_DISP, 1'b1, "R8 group tie local next");
        grant_once(5'b01001, 1'b0, G_PROC, 1'b1, "R8 group tie main again");
    endtask

    // USB burst of 1..4 beats; request dropped and foreign done raised mid-hold
    task automatic t_usb_len();
        do_reset();
        for (int len = 1; len <= 4; len++) begin
            req_i = G_USB;
            @(negedge clk);
            chk(gnt_o, G_USB, "R2 usb grant one edge after request");
            for (int k = 1; k <= len; k++) begin
                if (k == 2) req_i = '0;
                done_i = (k == len) ? G_USB : G_PROC;
                @(negedge clk);
                if (k < len) chk(gnt_o, G_USB, "R9 usb grant held");
                else         chk(gnt_o, G_NONE, "R10 usb released on done");
                if (k < len) chk(gnt_o, G_USB, "R10 foreign done ignored");
            end
            done_i = '0;
            req_i = '0;
            @(negedge clk);
        end
    endtask

    task automatic t_idle_gap();
        do_reset();
        req_i = G_PROC;
        @(negedge clk);
        chk(gnt_o, G_PROC, "R2 proc grant");
        done_i = G_PROC; req_i = G_DISP;
        @(negedge clk);
        chk(gnt_o, G_NONE, "R2 idle cycle after release");
        done_i = '0;
        @(negedge clk);
        chk(gnt_o, G_DISP, "R2 next grant after idle cycle");
        done_i = G_DISP; req_i = '0;
        @(negedge clk);
        done_i = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(gnt_o, G_NONE, "R11 no request no grant");
        end
    endtask

    task automatic t_reset_mid();
        do_reset();
        grant_once(5'b11000, 1'b0, G_DISP, 1'b1, "R7 display before reset");
        req_i = G_USB;
        @(negedge clk);
        chk(gnt_o, G_USB, "R9 usb held before reset");
        rst = 1'b1;
        @(negedge clk);
        chk(gnt_o, G_NONE, "R11 reset clears grant");
        rst = 1'b0; req_i = '0;
        grant_once(5'b11000, 1'b0, G_DISP, 1'b1, "R11 reset clears round-robin");
    endtask

    initial begin
        t_reset();
        t_refresh();
        t_burst();
        t_steal();
        t_local();
        t_top();
        t_usb_len();
        t_idle_gap();
        t_reset_mid();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P*20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule